// File: doc/BRIEF.md
# Pixel Time-of-Flight Converter Array

This block measures photon arrival time for every pixel of a small detector array. Each pixel owns a converter with two parts. A pseudo-random shift-register counter supplies the coarse time in reference-clock steps. A 3-bit phase code, taken from a delay line that all pixels share, supplies the fine time. A frame-start strobe seeds every pixel. While the measurement gate is high, each armed pixel advances its coarse counter on every selected reference tick.

The first stop pulse that a pixel's detector front end raises passes through a synchroniser. It then freezes that pixel's coarse state and samples the fine phase on the same edge, and the pixel reports a valid 13-bit word. A pixel that sees no stop before the gate closes reports a no-hit flag instead. Either result holds until the next frame start. Readout logic decodes the coarse state by stepping the same feedback polynomial from the seed.

The reference tick can come from either of two sources, the ring-oscillator tick or an external tick. A select input chooses between them.

Top module: `tof_tdc_array`

## Requirements
- R1: After reset every pixel shows valid_out=0 and nohit_out=0. Stop pulses that arrive before the first frame_start change neither flag.
- R2: A clock edge with frame_start=1 seeds every pixel's coarse state to all ones (0x3FF) and clears valid_out and nohit_out. This takes effect from the next cycle.
- R3: The coarse state steps as next = {s[8:0], s[9]^s[6]}, which is the polynomial x^10+x^7+1. It steps once per clock edge on which the pixel is armed, gate=1, the selected tick is 1, and no capture takes place. It never reaches zero.
- R4: Let a stop rising edge first be sampled high at edge k. Capture then happens at edge k+2. The coarse value is the state left by edge k+1, and the fine code is the fine_phase value present at edge k+2.
- R5: Pixel i (i = row*COLS+col) occupies word_out[13i+12:13i]. The coarse bits sit at [12:3] of that slice and the fine bits at [2:0].
- R6: Only the first capture in a frame counts. Later stop pulses leave valid_out and the word unchanged until the next frame_start.
- R7: An armed pixel goes to no-hit at the first edge that samples gate=0 after gate was 1. Its valid stays 0. A capture that would fall on that edge or later is refused.
- R8: With src_sel=0 the coarse counter follows osc_tick, and ext_tick has no effect. With src_sel=1 it follows ext_tick, and osc_tick has no effect.
- R9: Every pixel measures independently from its own stop input. One pixel's stop pulse does not touch any other pixel.
- R10: The coarse state does not change on an edge with gate=0. A pixel in the no-hit state therefore keeps the state it had when the window closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all pixels |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe that seeds and arms every pixel |
| gate | input | 1 | Measurement window; high while counting is allowed |
| src_sel | input | 1 | Tick source select: 0 ring-oscillator tick, 1 external tick |
| osc_tick | input | 1 | Count enable from the ring oscillator |
| ext_tick | input | 1 | Count enable from the external source |
| stop_in | input | ROWS*COLS | Per-pixel stop pulse from the detector front end (asynchronous) |
| fine_phase | input | FW | Shared delay-line phase code |
| word_out | output | ROWS*COLS*(CW+FW) | Per-pixel {coarse, fine} result words |
| valid_out | output | ROWS*COLS | Per-pixel capture flag |
| nohit_out | output | ROWS*COLS | Per-pixel no-event flag |

## Verification
The bench opens two full 64-pixel frames. The frames use different stop delays, tick patterns and tick sources. For every pixel the bench computes the expected coarse word by stepping the polynomial as many times as there were advancing edges before the capture edge.

One pixel gets its stop so that the capture would land exactly on the edge where the gate closes. A design that let a capture through on that edge would report a valid word where a no-hit flag is due. A second pulse on one pixel, and stops that arrive after the window has closed, expose a design that recaptures or leaks a capture after close. A wrong synchroniser depth or a counter that runs past the capture edge shows up as a coarse word one step off. A tick source that is selected backwards shows up as a wrong step count.

// File: rtl/tof_pkg.sv
package tof_pkg;

   typedef enum logic [1:0] {
      PX_IDLE  = 2'd0,
      PX_ARMED = 2'd1,
      PX_HIT   = 2'd2,
      PX_MISS  = 2'd3
   } px_state_e;

   // Feedback tap masks for maximal-length Fibonacci registers, bit i = stage i
   function automatic logic [31:0] lfsr_taps(input int unsigned w);
      logic [31:0] m;
      m = '0;
      case (w)
         3:  m = 32'h0000_0006;
         4:  m = 32'h0000_000C;
         5:  m = 32'h0000_0014;
         6:  m = 32'h0000_0030;
         7:  m = 32'h0000_0060;
         8:  m = 32'h0000_00B8;
         9:  m = 32'h0000_0110;
         10: m = 32'h0000_0240;
         11: m = 32'h0000_0500;
         12: m = 32'h0000_0E08;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/tof_lfsr.sv
module tof_lfsr #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         seed_load,
   input  logic         step_en,
   output logic [W-1:0] state
);
   localparam logic [31:0]  TAP_ALL = tof_pkg::lfsr_taps(W);
   localparam logic [W-1:0] TAPS    = TAP_ALL[W-1:0];
   localparam logic [W-1:0] SEED    = '1;

   initial begin
      assert (W >= 3 && W <= 12) else $error("tof_lfsr: W out of supported range");
   end

   logic          feedback;
   logic [W-1:0]  state_nx;

   always_comb begin
      feedback = ^(state & TAPS);
      state_nx = {state[W-2:0], feedback};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         state <= SEED;
      else if (seed_load) state <= SEED;
      else if (step_en)   state <= state_nx;
   end

   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0) else $error("coarse state reached zero"); // R3

   AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> state == SEED) else $error("seed not loaded"); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !seed_load) |=> $stable(state)) else $error("state moved without enable"); // R10

endmodule

// File: rtl/tof_stop_sync.sv
module tof_stop_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   initial begin
      assert (STAGES >= 2 && STAGES <= 4) else $error("tof_stop_sync: STAGES must be 2..4");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/tof_pixel.sv
module tof_pixel
   import tof_pkg::*;
#(
   parameter int unsigned CW          = 10,
   parameter int unsigned FW          = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned WW         = CW + FW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          gate,
   input  logic          gate_closed,
   input  logic          tick,
   input  logic          stop_in,
   input  logic [FW-1:0] fine_phase,
   output logic [WW-1:0] word,
   output logic          valid,
   output logic          nohit
);
   initial begin
      assert (FW >= 1 && FW <= 8) else $error("tof_pixel: FW out of range");
   end

   px_state_e      st;
   logic           stop_rise;
   logic           capture;
   logic           close_miss;
   logic           step_en;
   logic [CW-1:0]  coarse;
   logic [FW-1:0]  fine_q;

   tof_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (stop_in),
      .rise (stop_rise)
   );

   always_comb begin
      capture    = (st == PX_ARMED) && stop_rise && gate;
      close_miss = (st == PX_ARMED) && !capture && gate_closed;
      step_en    = (st == PX_ARMED) && gate && tick && !capture;
   end

   tof_lfsr #(.W(CW)) u_coarse (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_load(frame_start),
      .step_en  (step_en),
      .state    (coarse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PX_IDLE;
         fine_q <= '0;
      end else if (frame_start) begin
         st     <= PX_ARMED;
         fine_q <= '0;
      end else if (capture) begin
         st     <= PX_HIT;
         fine_q <= fine_phase;
      end else if (close_miss) begin
         st     <= PX_MISS;
      end
   end

   assign word  = {coarse, fine_q};
   assign valid = (st == PX_HIT);
   assign nohit = (st == PX_MISS);

   AST_FIRST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !frame_start) |=> (valid && $stable(word))) else $error("captured word moved"); // R6

   AST_CAPTURE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(gate)) else $error("capture outside window"); // R7

   AST_MISS_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nohit) |-> !$past(gate)) else $error("miss flagged while gate open"); // R7

   AST_SHUT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !frame_start) |=> $stable(word[WW-1:FW])) else $error("coarse moved with gate low"); // R10

endmodule

// File: rtl/tof_tdc_array.sv
module tof_tdc_array #(
   parameter int unsigned ROWS        = 8,
   parameter int unsigned COLS        = 8,
   parameter int unsigned CW          = 10,
   parameter int unsigned FW          = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NPIX       = ROWS * COLS,
   localparam int unsigned WW         = CW + FW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               gate,
   input  logic               src_sel,
   input  logic               osc_tick,
   input  logic               ext_tick,
   input  logic [NPIX-1:0]    stop_in,
   input  logic [FW-1:0]      fine_phase,
   output logic [NPIX*WW-1:0] word_out,
   output logic [NPIX-1:0]    valid_out,
   output logic [NPIX-1:0]    nohit_out
);
   initial begin
      assert (ROWS >= 1 && COLS >= 1 && NPIX <= 256) else $error("tof_tdc_array: array size out of range");
   end

   logic gate_d;
   logic gate_closed;
   logic ref_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_d <= 1'b0;
      else        gate_d <= gate;
   end

   always_comb begin
      gate_closed = gate_d & ~gate;
      ref_tick    = src_sel ? ext_tick : osc_tick;
   end

   genvar r, c;
   generate
      for (r = 0; r < ROWS; r++) begin : g_row
         for (c = 0; c < COLS; c++) begin : g_col
            localparam int unsigned IDX = r * COLS + c;
            tof_pixel #(
               .CW         (CW),
               .FW         (FW),
               .SYNC_STAGES(SYNC_STAGES)
            ) u_px (
               .clk        (clk),
               .rst_n      (rst_n),
               .frame_start(frame_start),
               .gate       (gate),
               .gate_closed(gate_closed),
               .tick       (ref_tick),
               .stop_in    (stop_in[IDX]),
               .fine_phase (fine_phase),
               .word       (word_out[IDX*WW +: WW]),
               .valid      (valid_out[IDX]),
               .nohit      (nohit_out[IDX])
            );
         end
      end
   endgenerate

   AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (valid_out == '0 && nohit_out == '0)) else $error("frame start did not clear flags"); // R2

endmodule

// File: tb/tb_tof_tdc_array.sv
`timescale 1ns/1ps
module tb_tof_tdc_array;
   localparam int NPIX = 64;
   localparam int WW   = 13;
   localparam int WD_CYCLES = 200000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_start = 1'b0;
   logic              gate = 1'b0;
   logic              src_sel = 1'b0;
   logic              osc_tick = 1'b0;
   logic              ext_tick = 1'b0;
   logic [NPIX-1:0]   stop_in = '0;
   logic [2:0]        fine_phase = '0;
   logic [NPIX*WW-1:0] word_out;
   logic [NPIX-1:0]   valid_out;
   logic [NPIX-1:0]   nohit_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   logic [WW-1:0] saved_word [NPIX];
   logic          saved_valid [NPIX];

   always #2.5 clk = ~clk;

   tof_tdc_array dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .gate(gate),
      .src_sel(src_sel), .osc_tick(osc_tick), .ext_tick(ext_tick),
      .stop_in(stop_in), .fine_phase(fine_phase),
      .word_out(word_out), .valid_out(valid_out), .nohit_out(nohit_out)
   );

   function automatic logic [9:0] lstep(input logic [9:0] s);
      return {s[8:0], s[9] ^ s[6]};
   endfunction

   function automatic logic [9:0] lpow(input int n);
      logic [9:0] s = 10'h3FF;
      for (int j = 0; j < n; j++) s = lstep(s);
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int pix, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s pixel %0d: actual %0h expected %0h", req, what, pix, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] pword(input int i);
      return word_out[i*WW +: WW];
   endfunction

   // mode 0: oscillator tick source; mode 1: external tick source
   task automatic run_frame(input int mode);
      int  raise_at [NPIX];
      bit  adv [128];
      logic [2:0] fph [128];
      int  g_end;
      int  last_k;
      int  cap, n;
      bit  hit;
      logic [9:0] exp_c;
      logic [WW-1:0] w;

      if (mode == 0) g_end = 40; else g_end = 30;
      for (int i = 0; i < NPIX; i++) begin
         if (mode == 0) raise_at[i] = (i % 4 == 3) ? -1 : 2 + ((i * 5) % 23);
         else           raise_at[i] = (i % 5 == 4) ? -1 : 1 + ((i * 7) % 31);
      end
      last_k = g_end + 12;

      // quiet period: stops low so every synchroniser flushes
      stop_in = '0; gate = 1'b0; frame_start = 1'b0;
      repeat (4) begin @(posedge clk); @(negedge clk); end

      if (mode == 1) begin
         for (int i = 0; i < NPIX; i++) begin
            check(valid_out[i] == saved_valid[i], "R6", "valid held to next frame", i, valid_out[i], saved_valid[i]);
            check(pword(i) == saved_word[i], "R6", "word held to next frame", i, pword(i), saved_word[i]);
         end
      end

      src_sel = (mode == 1);
      frame_start = 1'b1;
      @(posedge clk); @(negedge clk);       // edge 0
      frame_start = 1'b0;
      for (int i = 0; i < NPIX; i++) begin
         check(valid_out[i] == 1'b0 && nohit_out[i] == 1'b0, "R2", "flags after frame start", i,
               {valid_out[i], nohit_out[i]}, 0);
         check(pword(i)[12:3] == 10'h3FF, "R2", "seed", i, pword(i)[12:3], 10'h3FF);
      end

      for (int k = 1; k <= last_k; k++) begin
         gate = (k >= 2 && k < g_end);
         if (mode == 0) begin
            osc_tick = (k % 7 != 0);
            ext_tick = k[0];
         end else begin
            ext_tick = (k % 3 != 0);
            osc_tick = (k % 3 == 0);
         end
         fine_phase = 3'((k * 5 + 1) & 7);
         fph[k] = fine_phase;
         adv[k] = gate && (src_sel ? ext_tick : osc_tick);
         for (int i = 0; i < NPIX; i++) begin
            if (raise_at[i] < 0) stop_in[i] = 1'b0;
            else if (i == 0)     stop_in[i] = (k > raise_at[i]) && !(k > raise_at[i] + 3 && k <= raise_at[i] + 6);
            else                 stop_in[i] = (k > raise_at[i]);
         end
         @(posedge clk); @(negedge clk);
      end

      for (int i = 0; i < NPIX; i++) begin
         cap = raise_at[i] + 3;
         hit = (raise_at[i] >= 0) && (cap < g_end);
         n = 0;
         if (hit) begin
            for (int j = 1; j < cap; j++) n += adv[j];
         end else begin
            for (int j = 1; j < g_end; j++) n += adv[j];
         end
         exp_c = lpow(n);
         w = pword(i);
         if (hit) begin
            check(valid_out[i] == 1'b1, "R4", "valid after stop", i, valid_out[i], 1);
            check(nohit_out[i] == 1'b0, "R9", "no stray miss", i, nohit_out[i], 0);
            check(w[12:3] == exp_c, (mode == 0) ? "R3" : "R8", "coarse at capture", i, w[12:3], exp_c);
            check(w[2:0] == fph[cap], "R5", "fine code at capture edge", i, w[2:0], fph[cap]);
         end else begin
            check(valid_out[i] == 1'b0, "R7", "no valid without in-window stop", i, valid_out[i], 0);
            check(nohit_out[i] == 1'b1, "R7", "miss flag after close", i, nohit_out[i], 1);
            check(w[12:3] == exp_c, "R10", "coarse frozen at close", i, w[12:3], exp_c);
         end
         saved_word[i]  = w;
         saved_valid[i] = valid_out[i];
      end
      // pixel 0 got a second pulse: its result must still be the first capture
      check(valid_out[0] == 1'b1, "R6", "second pulse ignored", 0, valid_out[0], 1);
      stop_in = '0;
   endtask

   initial begin
      #(WD_CYCLES * 5.0);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NPIX; i++)
         check(valid_out[i] == 1'b0 && nohit_out[i] == 1'b0, "R1", "flags after reset", i,
               {valid_out[i], nohit_out[i]}, 0);

      // stops before any frame start must be ignored
      gate = 1'b1; osc_tick = 1'b1;
      stop_in = '1;
      repeat (6) begin @(posedge clk); @(negedge clk); end
      stop_in = '0;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      gate = 1'b0;
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < NPIX; i++)
         check(valid_out[i] == 1'b0 && nohit_out[i] == 1'b0, "R1", "stops before frame ignored", i,
               {valid_out[i], nohit_out[i]}, 0);

      run_frame(0);
      run_frame(1);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule